// File: doc/BRIEF.md
# Memory-Based Programmable Delay Line

This block delays a single-bit serial stream by a number of clock cycles chosen at run time. The delayed bits are not held in a long chain of flip-flops. They are kept in a one-bit-wide single-port synchronous RAM. One address counter walks through the RAM, and on every enabled cycle the port returns the bit held at the current address and stores the incoming bit in its place. A location is revisited exactly N enabled cycles after it was last written, so the output trails the input by N.

The address comes from a down counter that is one bit wider than the RAM index. Its top bit acts as a sign flag. When the count has stepped below zero, the sign bit alone selects a reload of N minus 2 on the next enabled edge; otherwise the count decrements. The addresses N-2 down to 0 and the all-ones address are visited, which is N locations in total. The length input is clamped into the supported range and sampled only at a pass boundary, when the counter reloads. A valid flag shows when the output bit comes from a completed pass that used the same length.

The RAM index is `ADDR_W` bits wide, and the RAM port address is a fixed 14 bits, zero-extended. The default of 12 index bits gives 4096 entries, which covers lengths up to 4096. Setting `ADDR_W` to 14 fills the whole 16K address space.

Top module: `dly_ram_line`

## Requirements
- R1: While `rst_n` is low and after its release, before any enabled edge, `dout` and `dout_vld` are 0.
- R2: With a constant effective length N, the `dout` value after the k-th enabled rising edge equals the `din` value sampled at the (k-N)-th enabled edge, whenever `dout_vld` is 1.
- R3: The minimum length is 2. A `len` value of 0 or 1 behaves exactly like 2, and the effective length is always between 2 and the RAM depth.
- R4: The maximum length equals the RAM depth, 2^`ADDR_W` (4096 by default). A `len` value above the depth behaves exactly like the depth.
- R5: When `en` is 0, the counter, the RAM, `dout` and `dout_vld` all hold their values, and `din` and `len` have no effect.
- R6: After reset, `dout_vld` is 0 for the first N enabled edges and becomes 1 at edge N+1 when `len` is held at N.
- R7: `len` is sampled only at a pass boundary, the enabled edge on which the counter is negative. If the new effective length differs from the previous one, `dout_vld` is 0 for that whole pass of new length N, and after it R2 holds with the new N. If the clamped value is unchanged, `dout_vld` stays 1.
- R8: The address counter decrements by one on each enabled edge while its sign bit is clear. On an enabled edge with the sign bit set, it reloads the effective length minus 2. A non-negative count never exceeds depth minus 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable; when low, nothing advances |
| din | input | 1 | Serial data in |
| len | input | ADDR_W+1 | Requested delay length in cycles, clamped to [2, 2^ADDR_W] |
| dout | output | 1 | Serial data out, delayed by the effective length |
| dout_vld | output | 1 | High when `dout` comes from a full pass of the current length |

## Verification
The RAM read and the valid flag are both registered at the port, so each result appears one register after the enabled edge that produced it. The input captured at enabled edge k shows up on `dout` right after enabled edge k+N. The bench drives inputs on the falling edge and samples one time unit after the rising edge. It keeps a count of enabled edges only, so that idle cycles do not stretch the expected delay. A length change is tracked by a model of the pass position in the bench, which counts upward and picks up a new length only at pass start. The bench therefore knows which edge begins the invalid pass and when the new delay first applies.

// File: rtl/dly_pkg.sv
package dly_pkg;

  // Clamp a requested length into [2, depth].
  function automatic int clamp_len(input int req, input int depth);
    if (req < 2)          return 2;
    else if (req > depth) return depth;
    else                  return req;
  endfunction

  // Reload value of the down counter for an effective length.
  function automatic int reload_of(input int eff_len);
    return eff_len - 2;
  endfunction

endpackage

// File: rtl/dly_spram.sv
module dly_spram #(
  parameter int ADDR_W = 12,
  parameter int RAM_AW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [RAM_AW-1:0] addr,
  input  logic              wdata,
  output logic              rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              mem [DEPTH];
  logic              in_range;
  logic [ADDR_W-1:0] idx;

  generate
    if (RAM_AW > ADDR_W) begin : g_hi
      assign in_range = (addr[RAM_AW-1:ADDR_W] == '0);
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  assign idx = addr[ADDR_W-1:0];

  // Write side: tied-active write enable gated by the clock enable.
  always_ff @(posedge clk) begin
    if (en && we && in_range) mem[idx] <= wdata;
  end

  // Read-first: the registered output takes the old contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= 1'b0;
    else if (en) rdata <= in_range ? mem[idx] : 1'b0;
  end
endmodule

// File: rtl/dly_mod_counter.sv
module dly_mod_counter #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [CW-1:0] cnt_nxt;

  // The sign bit selects the reload directly, so no compare follows the
  // subtraction.
  assign wrap    = cnt[CW-1];
  assign cnt_nxt = wrap ? reload_val : (cnt - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '1;
    else if (en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/dly_len_ctrl.sv
module dly_len_ctrl #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wrap,
  input  logic [LEN_W-1:0] len_in,
  output logic [LEN_W-1:0] len_eff,
  output logic [LEN_W-1:0] reload_val,
  output logic [LEN_W-1:0] len_act,
  output logic             dout_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  logic pass_ok;
  logic same_len;

  assign len_eff    = LEN_W'(dly_pkg::clamp_len(int'(len_in), DEPTH));
  assign reload_val = LEN_W'(dly_pkg::reload_of(int'(len_eff)));
  assign same_len   = (len_eff == len_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_act  <= '0;
      pass_ok  <= 1'b0;
      dout_vld <= 1'b0;
    end else if (en) begin
      if (wrap) begin
        len_act  <= len_eff;
        pass_ok  <= same_len;
        dout_vld <= same_len;
      end else begin
        dout_vld <= pass_ok;
      end
    end
  end
endmodule

// File: rtl/dly_ram_line.sv
module dly_ram_line #(
  parameter int ADDR_W = 12,
  parameter int RAM_AW = 14,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             din,
  input  logic [LEN_W-1:0] len,
  output logic             dout,
  output logic             dout_vld
);
  localparam int CW = ADDR_W + 1;

  logic [CW-1:0]     addr_cnt;
  logic              cnt_wrap;
  logic [LEN_W-1:0]  len_eff;
  logic [LEN_W-1:0]  len_act;
  logic [LEN_W-1:0]  reload_val;
  logic [RAM_AW-1:0] ram_addr;

  dly_len_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .en(en), .wrap(cnt_wrap), .len_in(len),
    .len_eff(len_eff), .reload_val(reload_val), .len_act(len_act),
    .dout_vld(dout_vld)
  );

  dly_mod_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .reload_val(CW'(reload_val)),
    .cnt(addr_cnt), .wrap(cnt_wrap)
  );

  assign ram_addr = RAM_AW'(addr_cnt[ADDR_W-1:0]);

  dly_spram #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .en(en), .we(1'b1), .addr(ram_addr),
    .wdata(din), .rdata(dout)
  );
endmodule

// File: rtl/dly_ram_line_chk.sv
module dly_ram_line_chk #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = ADDR_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             dout,
  input logic             dout_vld,
  input logic [ADDR_W:0]  addr_cnt,
  input logic             cnt_wrap,
  input logic [LEN_W-1:0] len_eff
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = ADDR_W + 1;

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(dout) && $stable(dout_vld) && $stable(addr_cnt)));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_wrap) |=> (addr_cnt == $past(addr_cnt) - CW'(1)));

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_wrap) |=> (addr_cnt == (CW'($past(len_eff)) - CW'(2))));

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_cnt[CW-1] |-> (int'(addr_cnt[CW-2:0]) <= DEPTH - 2));

  p_eff_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(len_eff) >= 2) && (int'(len_eff) <= DEPTH));

  p_vld_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_vld) |-> $past(en && cnt_wrap));
endmodule

bind dly_ram_line dly_ram_line_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dout(dout), .dout_vld(dout_vld),
  .addr_cnt(addr_cnt), .cnt_wrap(cnt_wrap), .len_eff(len_eff)
);

// File: tb/tb_dly_ram_line.sv
module tb_dly_ram_line;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = ADDR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HMASK  = 8191;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             din = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic             dout;
  logic             dout_vld;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference model state: counts enabled edges, pass position counts up.
  bit hist [8192];
  int k_edge  = 0;
  int pos     = 0;
  int cur_len = 0;
  bit vld_m   = 1'b0;
  bit exp_d   = 1'b0;

  dly_ram_line #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .len(len),
    .dout(dout), .dout_vld(dout_vld)
  );

  always #5 clk = ~clk;

  function automatic int bclamp(input int r);
    if (r < 2) return 2;
    if (r > DEPTH) return DEPTH;
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", tag, what, act, exp, k_edge);
    end
  endtask

  // One clock: drive on falling edge, sample 1 unit after rising edge.
  task automatic step(input bit e, input bit d, input int l, input string tag);
    bit prev_d, prev_v;
    @(negedge clk);
    en = e; din = d; len = LEN_W'(l);
    prev_d = dout; prev_v = dout_vld;
    @(posedge clk);
    #1;
    if (!e) begin
      // R5: nothing advances while disabled
      check("R5", int'(dout), int'(prev_d), "dout hold");
      check("R5", int'(dout_vld), int'(prev_v), "vld hold");
    end else begin
      if (pos == 0) begin
        int nl;
        nl = bclamp(l);
        vld_m = (nl == cur_len);
        cur_len = nl;
      end
      hist[k_edge & HMASK] = d;
      check(tag == "R7" ? "R7" : "R6", int'(dout_vld), int'(vld_m), "vld");
      if (vld_m) begin
        exp_d = hist[(k_edge - cur_len) & HMASK];
        // R2/R8: delay equals length through the modulo address walk
        check(tag, int'(dout), int'(exp_d), "dout");
      end
      pos = (pos + 1 == cur_len) ? 0 : pos + 1;
      k_edge++;
    end
  endtask

  task automatic run(input int cycles, input int l, input int en_pct, input string tag);
    for (int i = 0; i < cycles; i++) begin
      bit e;
      e = (($urandom % 100) < en_pct);
      step(e, bit'($urandom % 2), l, tag);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(dout), 0, "reset dout");
    check("R1", int'(dout_vld), 0, "reset vld");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(dout), 0, "post-reset dout");
    check("R1", int'(dout_vld), 0, "post-reset vld");

    // R3 / R6: minimum length, valid after the first pass
    run(12, 2, 100, "R3");
    // R3: lengths 0 and 1 act as 2, so valid must not drop
    run(12, 0, 100, "R3");
    run(12, 1, 100, "R3");
    // R7: change to 5, then random enable gaps (R5)
    run(30, 5, 100, "R7");
    run(300, 5, 60, "R5");
    // R2: mid-length streams, then a change mid-pass (R7)
    run(150, 37, 100, "R2");
    run(400, 100, 100, "R7");
    // R4: maximum length, then an oversized request that clamps to it
    run(9000, DEPTH, 100, "R4");
    run(4300, 6000, 100, "R4");
    run(200, 3454, 100, "R7");
    run(7200, 3454, 90, "R2");
    // R2 / R7: random lengths with random enables
    for (int j = 0; j < 40; j++) begin
      int l;
      l = 2 + int'($urandom % 60);
      run(150, l, 80, "R2");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule